// File: doc/BRIEF.md
# Parallel Bus Register Access Bridge

This bridge gives host software a path into a data converter's internal configuration registers. The path uses the same 16-bit parallel bus that normally returns conversion results. The host sees three words in a small register window: a staging word to put on the bus, a captured word taken from the bus, and a command word. A command of 0x0001 runs one bus write cycle that drives the staging word. A command of 0x0003 runs one bus read cycle that samples the bus. Writing zero to the command word re-arms the bridge for the next command.

Each bus cycle holds chip-select together with either the write strobe or the read strobe low for a fixed, parameterised number of clocks. A done flag is raised when the cycle ends. The converter takes its configuration through command words sent on the data lines. Each word carries a register address in the high byte and a value in the low byte, and bit 15 set marks a read request for the 7-bit address below it. The bridge watches the words it writes and tracks whether the converter is in register mode or in conversion mode. The word 0xAF00 enters register mode and the all-zero word leaves it.

A register read is a sequence run by software. It writes the flagged address word, runs a bus read, keeps the low byte of the captured word, and then writes zero to leave register mode.

Top module: `pbus_reg_bridge`

## Requirements
- R1: After reset, pb_cs_n, pb_wr_n and pb_rd_n are high, pb_oe is low, pb_dout is zero, xfer_done and reg_mode are low, and every host word in the window reads as zero.
- R2: A host write to offset 0x080 stores the staging word, and a host read at 0x080 returns it. Offset 0x084 returns the captured word, 0x08C returns the last command word, and any other offset reads zero.
- R3: Writing 0x0001 to offset 0x08C, when the bridge is idle and armed, holds pb_cs_n and pb_wr_n low and pb_oe high for exactly STROBE_CYC clocks, starting in the cycle after the host write. Throughout that window pb_dout carries the staging word as it was at the start.
- R4: Writing 0x0003 to offset 0x08C, when the bridge is idle and armed, holds pb_cs_n and pb_rd_n low with pb_oe low for exactly STROBE_CYC clocks. pb_din is sampled in the last strobe cycle and becomes readable at 0x084 from the next cycle.
- R5: xfer_done rises in the first cycle after the strobes return high. It stays high until zero is written to the command word or a new bus cycle starts.
- R6: A start command is ignored while a bus cycle is in progress, and also after a bus cycle started, until zero has been written to the command word.
- R7: When a bus write of the word 0xAF00 completes, reg_mode goes high.
- R8: When a bus write of the word 0x0000 completes, reg_mode goes low. Completed bus writes of any other word leave reg_mode unchanged.
- R9: The captured word at 0x084 changes only when a bus read completes; bus writes leave it unchanged.
- R10: A non-zero command word other than 0x0001 or 0x0003 starts no bus cycle and does not disarm the bridge, but it is still stored and read back at 0x08C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for one cycle |
| host_addr | input | ADDR_W | Host byte offset |
| host_wdata | input | 16 | Host write word |
| host_rdata | output | 16 | Host read word for host_addr (combinational) |
| pb_cs_n | output | 1 | Bus chip-select, active low |
| pb_wr_n | output | 1 | Bus write strobe, active low |
| pb_rd_n | output | 1 | Bus read strobe, active low |
| pb_oe | output | 1 | High while the bridge drives pb_dout |
| pb_dout | output | 16 | Word driven onto the bus |
| pb_din | input | 16 | Word read from the bus |
| xfer_done | output | 1 | Bus cycle complete |
| reg_mode | output | 1 | High while the converter is in register mode |

## Verification
A command written at clock edge E moves the strobes in the cycle after E and holds them through edge E+STROBE_CYC. At that same edge the captured word, the mode flag and the done flag update. Host reads are combinational, so they reflect register state in the same cycle. The bench drives inputs shortly after each rising edge. It advances a behavioural model on the same edge and compares every output at the falling edge, so each expected value lines up with the register that produces it. Directed checks then count strobe cycles and probe the ignored-command cases through the host window and the bus pins.

// File: rtl/pbb_pkg.sv
package pbb_pkg;

    localparam int PB_W = 16;

    localparam int OFF_STAGE   = 'h080;
    localparam int OFF_CAPTURE = 'h084;
    localparam int OFF_COMMAND = 'h08C;

    localparam logic [PB_W-1:0] CMD_BUS_WRITE = 16'h0001;
    localparam logic [PB_W-1:0] CMD_BUS_READ  = 16'h0003;
    localparam logic [PB_W-1:0] WORD_ENTER_REG = 16'hAF00;
    localparam logic [PB_W-1:0] WORD_LEAVE_REG = 16'h0000;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } bus_op_e;

    typedef struct packed {
        bus_op_e         op;
        logic [PB_W-1:0] word;
    } xfer_t;

    function automatic bus_op_e decode_cmd(input logic [PB_W-1:0] cmd);
        bus_op_e r;
        case (cmd)
            CMD_BUS_WRITE: r = OP_WRITE;
            CMD_BUS_READ:  r = OP_READ;
            default:       r = OP_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pbb_host_regs.sv
module pbb_host_regs
    import pbb_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [PB_W-1:0]   host_wdata,
    output logic [PB_W-1:0]   host_rdata,
    input  logic              busy,
    input  logic              cap_valid,
    input  logic [PB_W-1:0]   cap_word,
    output xfer_t             start,
    output logic              done_clr
);

    localparam logic [ADDR_W-1:0] A_STAGE   = ADDR_W'(OFF_STAGE);
    localparam logic [ADDR_W-1:0] A_CAPTURE = ADDR_W'(OFF_CAPTURE);
    localparam logic [ADDR_W-1:0] A_COMMAND = ADDR_W'(OFF_COMMAND);

    logic [PB_W-1:0] stage_q;
    logic [PB_W-1:0] capture_q;
    logic [PB_W-1:0] command_q;
    logic            armed_q;

    logic hit_stage;
    logic hit_cmd;

    assign hit_stage = host_we && (host_addr == A_STAGE);
    assign hit_cmd   = host_we && (host_addr == A_COMMAND);
    assign done_clr  = hit_cmd && (host_wdata == WORD_LEAVE_REG);

    always_comb begin
        start.op   = OP_NONE;
        start.word = stage_q;
        if (hit_cmd && armed_q && !busy) begin
            start.op = decode_cmd(host_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q   <= '0;
            capture_q <= '0;
            command_q <= '0;
            armed_q   <= 1'b1;
        end else begin
            if (hit_stage) begin
                stage_q <= host_wdata;
            end
            if (hit_cmd) begin
                command_q <= host_wdata;
                if (host_wdata == '0) begin
                    armed_q <= 1'b1;
                end else if (start.op != OP_NONE) begin
                    armed_q <= 1'b0;
                end
            end
            if (cap_valid) begin
                capture_q <= cap_word;
            end
        end
    end

    always_comb begin
        case (host_addr)
            A_STAGE:   host_rdata = stage_q;
            A_CAPTURE: host_rdata = capture_q;
            A_COMMAND: host_rdata = command_q;
            default:   host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pbb_strobe_seq.sv
module pbb_strobe_seq
    import pbb_pkg::*;
#(
    parameter int STROBE_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  xfer_t           start,
    input  logic            done_clr,
    input  logic [PB_W-1:0] pb_din,
    output logic            pb_cs_n,
    output logic            pb_wr_n,
    output logic            pb_rd_n,
    output logic            pb_oe,
    output logic [PB_W-1:0] pb_dout,
    output logic            busy,
    output logic            done,
    output logic            cap_valid,
    output logic [PB_W-1:0] cap_word,
    output logic            wr_fin,
    output logic [PB_W-1:0] wr_word
);

    localparam int CNT_W = $clog2(STROBE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    xfer_t            cur_q;
    logic             done_q;
    logic             last_cyc;
    logic             is_wr;
    logic             is_rd;

    assign busy     = (cnt_q != '0);
    assign last_cyc = (cnt_q == CNT_ONE);
    assign is_wr    = busy && (cur_q.op == OP_WRITE);
    assign is_rd    = busy && (cur_q.op == OP_READ);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            cur_q  <= '{op: OP_NONE, word: '0};
            done_q <= 1'b0;
        end else begin
            if (start.op != OP_NONE) begin
                cnt_q <= CNT_LOAD;
                cur_q <= start;
            end else if (busy) begin
                cnt_q <= cnt_q - CNT_ONE;
            end
            if (last_cyc) begin
                done_q <= 1'b1;
            end else if (done_clr || (start.op != OP_NONE)) begin
                done_q <= 1'b0;
            end
        end
    end

    assign pb_cs_n   = !busy;
    assign pb_wr_n   = !is_wr;
    assign pb_rd_n   = !is_rd;
    assign pb_oe     = is_wr;
    assign pb_dout   = is_wr ? cur_q.word : '0;
    assign done      = done_q;
    assign cap_valid = last_cyc && is_rd;
    assign cap_word  = pb_din;
    assign wr_fin    = last_cyc && is_wr;
    assign wr_word   = cur_q.word;

endmodule

// File: rtl/pbb_mode_track.sv
module pbb_mode_track
    import pbb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_fin,
    input  logic [PB_W-1:0] wr_word,
    output logic            reg_mode
);

    logic mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else if (wr_fin) begin
            if (wr_word == WORD_ENTER_REG) begin
                mode_q <= 1'b1;
            end else if (wr_word == WORD_LEAVE_REG) begin
                mode_q <= 1'b0;
            end
        end
    end

    assign reg_mode = mode_q;

endmodule

// File: rtl/pbus_reg_bridge.sv
module pbus_reg_bridge
    import pbb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int STROBE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              pb_cs_n,
    output logic              pb_wr_n,
    output logic              pb_rd_n,
    output logic              pb_oe,
    output logic [15:0]       pb_dout,
    input  logic [15:0]       pb_din,
    output logic              xfer_done,
    output logic              reg_mode
);

    xfer_t           start;
    logic            done_clr;
    logic            busy;
    logic            cap_valid;
    logic [PB_W-1:0] cap_word;
    logic            wr_fin;
    logic [PB_W-1:0] wr_word;

    pbb_host_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .cap_valid  (cap_valid),
        .cap_word   (cap_word),
        .start      (start),
        .done_clr   (done_clr)
    );

    pbb_strobe_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .done_clr  (done_clr),
        .pb_din    (pb_din),
        .pb_cs_n   (pb_cs_n),
        .pb_wr_n   (pb_wr_n),
        .pb_rd_n   (pb_rd_n),
        .pb_oe     (pb_oe),
        .pb_dout   (pb_dout),
        .busy      (busy),
        .done      (xfer_done),
        .cap_valid (cap_valid),
        .cap_word  (cap_word),
        .wr_fin    (wr_fin),
        .wr_word   (wr_word)
    );

    pbb_mode_track u_mode (
        .clk      (clk),
        .rst      (rst),
        .wr_fin   (wr_fin),
        .wr_word  (wr_word),
        .reg_mode (reg_mode)
    );

endmodule

// File: rtl/pbb_checker.sv
module pbb_checker (
    input logic        clk,
    input logic        rst,
    input logic        pb_cs_n,
    input logic        pb_wr_n,
    input logic        pb_rd_n,
    input logic        pb_oe,
    input logic [15:0] pb_dout,
    input logic        xfer_done,
    input logic        reg_mode
);

    a_r3_wr_under_cs: assert property (@(posedge clk) disable iff (rst)
        !pb_wr_n |-> (!pb_cs_n && pb_oe));

    a_r4_rd_under_cs: assert property (@(posedge clk) disable iff (rst)
        !pb_rd_n |-> (!pb_cs_n && !pb_oe && pb_wr_n));

    a_r3_dout_steady: assert property (@(posedge clk) disable iff (rst)
        (!pb_wr_n && $past(!pb_wr_n)) |-> $stable(pb_dout));

    a_r5_done_at_end: assert property (@(posedge clk) disable iff (rst)
        $rose(pb_cs_n) |-> xfer_done);

    a_r6_no_done_mid_cycle: assert property (@(posedge clk) disable iff (rst)
        (!pb_cs_n && $past(!pb_cs_n)) |-> !xfer_done);

    a_r8_mode_moves_on_write_end: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_mode) |-> ($rose(pb_cs_n) && $past(!pb_wr_n)));

endmodule

bind pbus_reg_bridge pbb_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pb_cs_n   (pb_cs_n),
    .pb_wr_n   (pb_wr_n),
    .pb_rd_n   (pb_rd_n),
    .pb_oe     (pb_oe),
    .pb_dout   (pb_dout),
    .xfer_done (xfer_done),
    .reg_mode  (reg_mode)
);

// File: tb/pbus_reg_bridge_tb.sv
module pbus_reg_bridge_tb;

    localparam int ADDR_W = 12;
    localparam int S      = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [15:0]       host_wdata = '0;
    logic [15:0]       host_rdata;
    logic              pb_cs_n, pb_wr_n, pb_rd_n, pb_oe;
    logic [15:0]       pb_dout;
    logic [15:0]       pb_din = '0;
    logic              xfer_done, reg_mode;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pbus_reg_bridge #(.ADDR_W(ADDR_W), .STROBE_CYC(S)) u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pb_cs_n(pb_cs_n), .pb_wr_n(pb_wr_n), .pb_rd_n(pb_rd_n),
        .pb_oe(pb_oe), .pb_dout(pb_dout), .pb_din(pb_din),
        .xfer_done(xfer_done), .reg_mode(reg_mode)
    );

    // behavioural reference model
    int   m_cnt = 0;
    int   m_op  = 0;           // 0 none, 1 write, 2 read
    int   m_word = 0;
    int   m_stage = 0;
    int   m_capture = 0;
    int   m_cmd = 0;
    bit   m_armed = 1;
    bit   m_done = 0;
    bit   m_mode = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_op = 0; m_word = 0; m_stage = 0; m_capture = 0;
            m_cmd = 0; m_armed = 1; m_done = 0; m_mode = 0;
        end else begin
            int  st;
            bit  clr;
            bit  fin;
            st  = 0;
            clr = 0;
            fin = (m_cnt == 1);
            if (host_we && host_addr == 12'h08C) begin
                m_cmd = host_wdata;
                if (host_wdata == 0) begin
                    m_armed = 1; clr = 1;
                end else if (m_armed && m_cnt == 0 &&
                             (host_wdata == 16'h0001 || host_wdata == 16'h0003)) begin
                    st = (host_wdata == 16'h0001) ? 1 : 2;
                    m_armed = 0;
                end
            end
            if (fin) begin
                if (m_op == 2) m_capture = pb_din;
                else if (m_word == 'hAF00) m_mode = 1;
                else if (m_word == 0) m_mode = 0;
            end
            if (fin) m_done = 1;
            else if (clr || st != 0) m_done = 0;
            if (st != 0) begin
                m_cnt = S; m_op = st; m_word = m_stage;
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end
            if (host_we && host_addr == 12'h080) m_stage = host_wdata;
        end
    end

    function automatic int exp_rdata(input logic [ADDR_W-1:0] a);
        if (a == 12'h080) return m_stage;
        if (a == 12'h084) return m_capture;
        if (a == 12'h08C) return m_cmd;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit act_w;
            act_w = (m_cnt > 0 && m_op == 1);
            check("R3 cs_n",  pb_cs_n, (m_cnt == 0));
            check("R3 wr_n",  pb_wr_n, !act_w);
            check("R3 oe",    pb_oe,   act_w);
            check("R3 dout",  pb_dout, act_w ? m_word : 0);
            check("R4 rd_n",  pb_rd_n, !(m_cnt > 0 && m_op == 2));
            check("R5 done",  xfer_done, m_done);
            check("R7 mode",  reg_mode, m_mode);
            check("R2 rdata", host_rdata, exp_rdata(host_addr));
        end
    end

    task automatic host_write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #2;
        host_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic peek(input logic [ADDR_W-1:0] a, input string req, input int exp);
        host_addr = a;
        @(negedge clk);
        check(req, host_rdata, exp);
        @(posedge clk); #2;
    endtask

    // counts low cycles of cs_n after a command issued at the current point
    task automatic count_strobe(input string req, input bit want_rd);
        int n;
        int sn;
        n = 0; sn = 0;
        for (int i = 0; i < S + 4; i++) begin
            @(negedge clk);
            if (!pb_cs_n) n++;
            if (want_rd ? !pb_rd_n : !pb_wr_n) sn++;
        end
        check(req, n, S);
        check(req, sn, S);
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        check("R1 cs_n", pb_cs_n, 1);
        check("R1 wr_n", pb_wr_n, 1);
        check("R1 rd_n", pb_rd_n, 1);
        check("R1 oe",   pb_oe,   0);
        check("R1 dout", pb_dout, 0);
        check("R1 done", xfer_done, 0);
        check("R1 mode", reg_mode, 0);
        @(posedge clk); #2;
        peek(12'h080, "R1 stage", 0);
        peek(12'h084, "R1 capture", 0);
        peek(12'h08C, "R1 command", 0);

        // R2 staging word and unmapped offset
        host_write(12'h080, 16'h1234);
        peek(12'h080, "R2 stage", 16'h1234);
        peek(12'h088, "R2 unmapped", 0);

        // R3 bus write of an ordinary word, R8 mode unchanged
        host_write(12'h08C, 16'h0001);
        host_write(12'h08C, 16'h0003);   // R6 while busy: ignored
        idle(S + 2);
        check("R8 mode unchanged", reg_mode, 0);
        check("R5 done held", xfer_done, 1);

        // R6 no re-arm: read command ignored
        host_write(12'h08C, 16'h0003);
        begin
            int low;
            low = 0;
            for (int i = 0; i < S + 2; i++) begin
                @(negedge clk);
                if (!pb_cs_n) low++;
            end
            check("R6 ignored without re-arm", low, 0);
            @(posedge clk); #2;
        end

        // R5 done cleared by zero command
        host_write(12'h08C, 16'h0000);
        @(negedge clk);
        check("R5 done cleared", xfer_done, 0);
        @(posedge clk); #2;

        // R7 enter register mode, with strobe length counted
        host_write(12'h080, 16'hAF00);
        host_write(12'h08C, 16'h0001);
        count_strobe("R3 write strobe length", 0);
        check("R7 mode entered", reg_mode, 1);
        host_write(12'h08C, 16'h0000);

        // R4 register read sequence
        host_write(12'h080, 16'h8500);
        host_write(12'h08C, 16'h0001);
        idle(S + 1);
        host_write(12'h08C, 16'h0000);
        pb_din = 16'h5AC3;
        host_write(12'h08C, 16'h0003);
        count_strobe("R4 read strobe length", 1);
        peek(12'h084, "R4 captured", 16'h5AC3);
        host_write(12'h08C, 16'h0000);
        pb_din = 16'h0F0F;

        // R8 leave register mode, R9 capture untouched by writes
        host_write(12'h080, 16'h0000);
        host_write(12'h08C, 16'h0001);
        idle(S + 2);
        check("R8 mode left", reg_mode, 0);
        peek(12'h084, "R9 capture held", 16'h5AC3);
        host_write(12'h08C, 16'h0000);

        // R10 unknown command: stored, no cycle, stays armed
        host_write(12'h08C, 16'h0007);
        begin
            int low;
            low = 0;
            for (int i = 0; i < S + 2; i++) begin
                @(negedge clk);
                if (!pb_cs_n) low++;
            end
            check("R10 no cycle", low, 0);
            @(posedge clk); #2;
        end
        peek(12'h08C, "R10 command readback", 16'h0007);
        host_write(12'h08C, 16'h0003);
        idle(S + 2);
        peek(12'h084, "R10 still armed R9 new capture", 16'h0F0F);

        idle(3);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule